// File: doc/BRIEF.md
# Instruction Decode and Address Generation

This block is the combinational decode stage of a small 16-bit load/store processor with eight general registers. One instruction word comes in, together with the incremented program counter, two register read values, the current condition flags and the privilege bit. In the same cycle the block returns three register selects, an operation class, the second ALU operand, the effective memory address with read and write requests, the next program counter, and control flags. The flags cover condition-code update, link-register write, indirect access and the two exceptions.

A sequencer wraps the block. It owns the register file, the memory port and the two-access handling of indirect loads and stores. It feeds the written-back value through `wb_value` and gets back the flag triple that the condition codes should take. Three address forms are computed, each with its own offset width: PC-relative, base plus offset, and trap-table.

Top module: `instr_decode`

## Requirements
- R1: Opcode 4'b1101 in bits [15:12] sets `exc_illegal`, gives `op_class` 11, and holds `mem_rd`, `mem_wr`, `cc_update` and `link_write` low.
- R2: For ADD (0001, class 0) and AND (0101, class 1), `operand_b` is `src_b` when bit 5 is 0. When bit 5 is 1, it is bits [4:0] sign-extended to 16 bits.
- R3: LD (0010), LDI (1010), LEA (1110), ST (0011) and STI (1011) address `pc_inc` plus bits [8:0] sign-extended.
- R4: JSR/JSRR (0100) raise `link_write` with `dst_sel` 7 and `branch_taken`. The next PC is `pc_inc` plus bits [10:0] sign-extended when bit 11 is 1, and `src_a` when bit 11 is 0.
- R5: LDR (0110) reads and STR (0111) writes at `src_a` plus bits [5:0] sign-extended, with `sel_a` = bits [8:6]. Read and write are never requested together.
- R6: BR (0000) is taken when bits {11,10,9} AND {N,Z,P} is non-zero. The next PC is then `pc_inc` plus the 9-bit offset. Otherwise the next PC stays `pc_inc` and `branch_taken` is 0.
- R7: JMP (1100) sets the next PC to `src_a` with `sel_a` = bits [8:6]; bits [8:6] = 7 gives the return form.
- R8: TRAP (1111) raises `link_write` with `dst_sel` 7, and requests a read at bits [7:0] zero-extended. The next PC stays `pc_inc`.
- R9: `cc_update` is high only for ADD, AND, NOT (1001), LD, LDI, LDR and LEA. `cc_next` = {N,Z,P} has exactly one bit set, by the sign of `wb_value`.
- R10: RTI (1000) with `user_mode` 1 sets `exc_priv` and no memory request. With `user_mode` 0, it selects register 6 on `sel_a` and requests a read at `src_a`.
- R11: LEA requests no memory read; its write value is `mem_addr`.
- R12: `indirect` is 1 for LDI and STI only, and always comes with a memory request.
- R13: `dst_sel` is bits [11:9] except for link writes. `sel_b` is bits [11:9] for ST, STI and STR, and bits [2:0] otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Address of the following instruction |
| src_a | input | 16 | Register value read through `sel_a` |
| src_b | input | 16 | Register value read through `sel_b` |
| flag_n | input | 1 | Current negative flag |
| flag_z | input | 1 | Current zero flag |
| flag_p | input | 1 | Current positive flag |
| user_mode | input | 1 | 1 when running unprivileged |
| wb_value | input | 16 | Value being written back, for flag generation |
| dst_sel | output | 3 | Destination register |
| sel_a | output | 3 | First read register (source 1 or base) |
| sel_b | output | 3 | Second read register (source 2 or store data) |
| op_class | output | 4 | Operation class code |
| operand_b | output | 16 | Second ALU operand |
| mem_addr | output | 16 | Effective address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| next_pc | output | 16 | Next program counter |
| branch_taken | output | 1 | Control transfer to a computed target |
| cc_update | output | 1 | Condition codes take `cc_next` |
| cc_next | output | 3 | New {N,Z,P} from `wb_value` |
| link_write | output | 1 | Write `pc_inc` into register 7 |
| indirect | output | 1 | Access needs a second memory cycle |
| exc_illegal | output | 1 | Reserved opcode exception |
| exc_priv | output | 1 | Privileged return in user mode |

## Verification
The in-line checks assume that every input carries a known 0/1 value whenever outputs are sampled. They also assume the flag inputs come from a previous one-hot update, though the decode logic does not rely on that. The bench drives every input before each sample, and holds `src_a`, `src_b` and `wb_value` at fixed known patterns. The offsets it chooses reach the extreme values of each field, so that sign extension and address wrap are visible at the ports.

// File: rtl/instr_decode.sv
module instr_decode (
  input  logic [15:0] instr,
  input  logic [15:0] pc_inc,
  input  logic [15:0] src_a,
  input  logic [15:0] src_b,
  input  logic        flag_n,
  input  logic        flag_z,
  input  logic        flag_p,
  input  logic        user_mode,
  input  logic [15:0] wb_value,
  output logic [2:0]  dst_sel,
  output logic [2:0]  sel_a,
  output logic [2:0]  sel_b,
  output logic [3:0]  op_class,
  output logic [15:0] operand_b,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] next_pc,
  output logic        branch_taken,
  output logic        cc_update,
  output logic [2:0]  cc_next,
  output logic        link_write,
  output logic        indirect,
  output logic        exc_illegal,
  output logic        exc_priv
);
  localparam logic [3:0] CLS_ADD = 4'd0, CLS_AND = 4'd1, CLS_NOT = 4'd2,
                         CLS_LOAD = 4'd3, CLS_STORE = 4'd4, CLS_LEA = 4'd5,
                         CLS_BRANCH = 4'd6, CLS_JUMP = 4'd7, CLS_CALL = 4'd8,
                         CLS_TRAP = 4'd9, CLS_RTI = 4'd10, CLS_EXC = 4'd11;

  logic [3:0]  opc;
  logic [15:0] imm5_x, pc_rel9, pc_rel11, base_off6, trap_addr;
  logic        cond_hit;

  assign opc       = instr[15:12];
  assign imm5_x    = {{11{instr[4]}}, instr[4:0]};
  assign pc_rel9   = pc_inc + {{7{instr[8]}}, instr[8:0]};
  assign pc_rel11  = pc_inc + {{5{instr[10]}}, instr[10:0]};
  assign base_off6 = src_a + {{10{instr[5]}}, instr[5:0]};
  assign trap_addr = {8'h00, instr[7:0]};
  assign cond_hit  = |(instr[11:9] & {flag_n, flag_z, flag_p});

  assign cc_next[2] = wb_value[15];
  assign cc_next[1] = (wb_value == 16'h0000);
  assign cc_next[0] = !wb_value[15] && (wb_value != 16'h0000);

  always_comb begin
    dst_sel      = instr[11:9];
    sel_a        = instr[8:6];
    sel_b        = instr[2:0];
    op_class     = CLS_EXC;
    operand_b    = src_b;
    mem_addr     = pc_rel9;
    mem_rd       = 1'b0;
    mem_wr       = 1'b0;
    next_pc      = pc_inc;
    branch_taken = 1'b0;
    cc_update    = 1'b0;
    link_write   = 1'b0;
    indirect     = 1'b0;
    exc_illegal  = 1'b0;
    exc_priv     = 1'b0;
    case (opc)
      4'b0001, 4'b0101: begin
        op_class  = (opc == 4'b0001) ? CLS_ADD : CLS_AND;
        operand_b = instr[5] ? imm5_x : src_b;
        cc_update = 1'b1;
      end
      4'b1001: begin
        op_class  = CLS_NOT;
        cc_update = 1'b1;
      end
      4'b0010, 4'b1010: begin
        op_class  = CLS_LOAD;
        mem_rd    = 1'b1;
        indirect  = opc[3];
        cc_update = 1'b1;
      end
      4'b0110: begin
        op_class  = CLS_LOAD;
        mem_addr  = base_off6;
        mem_rd    = 1'b1;
        cc_update = 1'b1;
      end
      4'b1110: begin
        op_class  = CLS_LEA;
        cc_update = 1'b1;
      end
      4'b0011, 4'b1011: begin
        op_class = CLS_STORE;
        sel_b    = instr[11:9];
        mem_wr   = 1'b1;
        indirect = opc[3];
      end
      4'b0111: begin
        op_class = CLS_STORE;
        sel_b    = instr[11:9];
        mem_addr = base_off6;
        mem_wr   = 1'b1;
      end
      4'b0000: begin
        op_class     = CLS_BRANCH;
        branch_taken = cond_hit;
        next_pc      = cond_hit ? pc_rel9 : pc_inc;
      end
      4'b1100: begin
        op_class     = CLS_JUMP;
        next_pc      = src_a;
        branch_taken = 1'b1;
      end
      4'b0100: begin
        op_class     = CLS_CALL;
        dst_sel      = 3'd7;
        link_write   = 1'b1;
        next_pc      = instr[11] ? pc_rel11 : src_a;
        branch_taken = 1'b1;
      end
      4'b1111: begin
        op_class   = CLS_TRAP;
        dst_sel    = 3'd7;
        link_write = 1'b1;
        mem_addr   = trap_addr;
        mem_rd     = 1'b1;
      end
      4'b1000: begin
        sel_a    = 3'd6;
        mem_addr = src_a;
        if (user_mode) begin
          exc_priv = 1'b1;
        end else begin
          op_class = CLS_RTI;
          mem_rd   = 1'b1;
        end
      end
      default: exc_illegal = 1'b1;
    endcase
  end

  always_comb begin
    AST_EXC_QUIET: assert (!(exc_illegal || exc_priv) || !(mem_rd || mem_wr || cc_update || link_write)); // R1
    AST_RW_EXCL: assert (!(mem_rd && mem_wr)); // R5
    AST_CC_ONEHOT: assert ($onehot(cc_next)); // R9
    AST_LINK_R7: assert (!link_write || dst_sel == 3'd7); // R13
    AST_IND_MEM: assert (!indirect || mem_rd || mem_wr); // R12
    AST_LEA_NORD: assert (op_class != CLS_LEA || !mem_rd); // R11
  end
endmodule

// File: tb/instr_decode_bench.sv
module instr_decode_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] instr, pc_inc, src_a, src_b, wb_value;
  logic        flag_n, flag_z, flag_p, user_mode;
  logic [2:0]  dst_sel, sel_a, sel_b, cc_next;
  logic [3:0]  op_class;
  logic [15:0] operand_b, mem_addr, next_pc;
  logic        mem_rd, mem_wr, branch_taken, cc_update, link_write, indirect, exc_illegal, exc_priv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  instr_decode u_instr_decode (
    .instr(instr), .pc_inc(pc_inc), .src_a(src_a), .src_b(src_b),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p), .user_mode(user_mode),
    .wb_value(wb_value), .dst_sel(dst_sel), .sel_a(sel_a), .sel_b(sel_b),
    .op_class(op_class), .operand_b(operand_b), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .next_pc(next_pc), .branch_taken(branch_taken),
    .cc_update(cc_update), .cc_next(cc_next), .link_write(link_write),
    .indirect(indirect), .exc_illegal(exc_illegal), .exc_priv(exc_priv)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [2:0] nzp, input logic um);
    @(negedge clk);
    instr = w; {flag_n, flag_z, flag_p} = nzp; user_mode = um;
    #2;
  endtask

  task automatic t_reset;
    apply(16'h0000, 3'b111, 1'b0);
    chk("R6 reset taken", {15'd0, branch_taken}, 16'd0);
    chk("R6 reset npc", next_pc, 16'h3001);
    chk("R9 reset cc", {15'd0, cc_update}, 16'd0);
    chk("R5 reset mem", {14'd0, mem_rd, mem_wr}, 16'd0);
  endtask

  task automatic t_alu;
    apply(16'h14C4, 3'b010, 1'b0);
    chk("R2 add reg", operand_b, 16'h1234);
    chk("R13 add sel", {7'd0, dst_sel, sel_a, sel_b}, {7'd0, 3'd2, 3'd3, 3'd4});
    chk("R9 add cc", {11'd0, cc_update, op_class}, {11'd0, 1'b1, 4'd0});
    apply(16'h14FD, 3'b010, 1'b0);
    chk("R2 add imm", operand_b, 16'hFFFD);
    apply(16'h54E7, 3'b010, 1'b0);
    chk("R2 and imm", operand_b, 16'h0007);
    chk("R2 and class", {12'd0, op_class}, 16'd1);
    apply(16'h94FF, 3'b010, 1'b0);
    chk("R9 not cc", {11'd0, cc_update, op_class}, {11'd0, 1'b1, 4'd2});
  endtask

  task automatic t_pcrel;
    apply(16'h23FF, 3'b010, 1'b0);
    chk("R3 ld addr", mem_addr, 16'h3000);
    chk("R12 ld flags", {12'd0, mem_rd, mem_wr, indirect, cc_update}, {12'd0, 4'b1001});
    apply(16'hA205, 3'b010, 1'b0);
    chk("R12 ldi", {12'd0, mem_rd, mem_wr, indirect, cc_update}, {12'd0, 4'b1011});
    chk("R3 ldi addr", mem_addr, 16'h3006);
    apply(16'hBA02, 3'b010, 1'b0);
    chk("R12 sti", {12'd0, mem_rd, mem_wr, indirect, cc_update}, {12'd0, 4'b0110});
    chk("R13 sti selb", {13'd0, sel_b}, 16'd5);
    apply(16'h3700, 3'b010, 1'b0);
    chk("R3 st addr", mem_addr, 16'h2F01);
    chk("R13 st selb", {13'd0, sel_b}, 16'd3);
    apply(16'hE8FF, 3'b010, 1'b0);
    chk("R11 lea addr", mem_addr, 16'h3100);
    chk("R11 lea nord", {14'd0, mem_rd, cc_update}, 16'd1);
  endtask

  task automatic t_base;
    apply(16'h62A0, 3'b010, 1'b0);
    chk("R5 ldr addr", mem_addr, 16'h3FE0);
    chk("R5 ldr flags", {13'd0, sel_a, mem_rd, mem_wr}, {13'd0, 3'd2, 2'b10});
    apply(16'h7C9F, 3'b010, 1'b0);
    chk("R5 str addr", mem_addr, 16'h401F);
    chk("R13 str selb", {11'd0, sel_b, mem_rd, mem_wr}, {11'd0, 3'd6, 2'b01});
  endtask

  task automatic t_branch;
    apply(16'h0410, 3'b010, 1'b0);
    chk("R6 brz taken", {15'd0, branch_taken}, 16'd1);
    chk("R6 brz npc", next_pc, 16'h3011);
    apply(16'h0410, 3'b100, 1'b0);
    chk("R6 brz miss", {15'd0, branch_taken}, 16'd0);
    chk("R6 brz miss npc", next_pc, 16'h3001);
    apply(16'h0BFE, 3'b001, 1'b0);
    chk("R6 brnp npc", next_pc, 16'h2FFF);
  endtask

  task automatic t_jump;
    apply(16'hC080, 3'b010, 1'b0);
    chk("R7 jmp npc", next_pc, 16'h5555);
    chk("R7 jmp sel", {12'd0, sel_a, branch_taken}, {12'd0, 3'd2, 1'b1});
    apply(16'hC1C0, 3'b010, 1'b0);
    chk("R7 ret sel", {13'd0, sel_a}, 16'd7);
    apply(16'h4BFF, 3'b010, 1'b0);
    chk("R4 jsr fwd", next_pc, 16'h3400);
    chk("R4 jsr link", {12'd0, link_write, dst_sel}, {12'd0, 1'b1, 3'd7});
    apply(16'h4C00, 3'b010, 1'b0);
    chk("R4 jsr back", next_pc, 16'h2C01);
    apply(16'h40C0, 3'b010, 1'b0);
    chk("R4 jsrr npc", next_pc, 16'h5555);
    chk("R4 jsrr link", {15'd0, link_write}, 16'd1);
  endtask

  task automatic t_trap;
    apply(16'hF025, 3'b010, 1'b0);
    chk("R8 trap addr", mem_addr, 16'h0025);
    chk("R8 trap flags", {11'd0, mem_rd, link_write, dst_sel}, {11'd0, 2'b11, 3'd7});
    chk("R8 trap npc", next_pc, 16'h3001);
  endtask

  task automatic t_except;
    apply(16'h8000, 3'b010, 1'b0);
    chk("R10 rti sup", {11'd0, exc_priv, mem_rd, sel_a}, {11'd0, 2'b01, 3'd6});
    chk("R10 rti addr", mem_addr, 16'h5555);
    apply(16'h8000, 3'b010, 1'b1);
    chk("R10 rti user", {14'd0, exc_priv, mem_rd}, 16'd2);
    apply(16'hD123, 3'b010, 1'b0);
    chk("R1 illegal", {11'd0, exc_illegal, mem_rd, mem_wr, cc_update, link_write}, {11'd0, 5'b10000});
    chk("R1 class", {12'd0, op_class}, 16'd11);
  endtask

  task automatic t_ccgen;
    apply(16'h14C4, 3'b010, 1'b0);
    wb_value = 16'h8000; #1;
    chk("R9 neg", {13'd0, cc_next}, 16'd4);
    wb_value = 16'h0000; #1;
    chk("R9 zero", {13'd0, cc_next}, 16'd2);
    wb_value = 16'h7FFF; #1;
    chk("R9 pos", {13'd0, cc_next}, 16'd1);
  endtask

  initial begin
    instr = 16'h0000; pc_inc = 16'h3001; src_a = 16'h5555; src_b = 16'h1234;
    wb_value = 16'h0001; flag_n = 1'b0; flag_z = 1'b1; flag_p = 1'b0; user_mode = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_alu();
    t_pcrel();
    src_a = 16'h4000;
    t_base();
    src_a = 16'h5555;
    t_branch();
    t_jump();
    t_trap();
    t_except();
    t_ccgen();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule